// File: doc/BRIEF.md
# Wrapping ADC Channel Scan Sequencer

This block supplies the input-channel code for each conversion of an analog burst. Software programs a first channel and a last channel with a single write. The sequencer then presents the first channel and moves one channel forward on each conversion-complete pulse. After the last channel it returns to the first channel and pulses a burst-done flag. If the last channel is numerically below the first, the scan wraps through the top of the channel space. In differential mode only half the channels exist, so the top bit of every channel code is dropped and the scan wraps modulo 8.

Each channel write starts an internal settling reset. A busy flag stays high for a fixed, parameterised number of cycles. While it is high, conversion pulses are ignored. The interface is plain control and status: pulses in, levels out. There is no valid/ready handshake and no back-pressure. The converter must not issue conversion pulses that it expects to count while the busy flag is high.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held and after it is released, `chan` is 0, `burst_done` is 0 and `rst_busy` is 0.
- R2: A cycle with `cfg_wr` high stores `cfg_data[3:0]` as the first channel and `cfg_data[7:4]` as the last channel. In the next cycle, `chan` shows the first channel, masked according to R8.
- R3: `rst_busy` goes high in the cycle after a `cfg_wr` and stays high for exactly `BUSY_CYCLES` cycles. A new write restarts the full window.
- R4: A `conv_done` pulse is ignored if `rst_busy` is high or `cfg_wr` is high in the same cycle. It changes neither `chan` nor `burst_done`.
- R5: An accepted `conv_done` pulse with `chan` not equal to the last channel makes `chan` the next code in the following cycle.
- R6: An accepted `conv_done` pulse with `chan` equal to the last channel reloads the first channel. In the next cycle it raises `burst_done` for one cycle.
- R7: In single-ended mode (`diff_mode`=0) the increment wraps from 15 to 0. With first=9 and last=1 the scan is 9,10,...,15,0,1,9.
- R8: With `diff_mode`=1, bit 3 of the first, last and current channel is ignored. `chan[3]` reads 0 and the increment wraps from 7 to 0. With first=3 and last=13 the scan is 3,4,5,3.
- R9: With no write and no `conv_done`, `chan` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Channel-register write strobe |
| cfg_data | input | 8 | First channel in [3:0], last channel in [7:4] |
| diff_mode | input | 1 | 1 = 8 differential channels, 0 = 16 single-ended |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| chan | output | 4 | Channel code for the next conversion |
| burst_done | output | 1 | One-cycle pulse after the last channel of a burst |
| rst_busy | output | 1 | Internal reset after a write is in progress |

## Verification
The bench aims at five corner cases:
- **Wrapped scan (last below first).** A design comparing with "greater than" instead of equality would run past the last channel or stall at 15.
- **Differential mask.** A design keeping bit 3 would scan 3 through 13 instead of 3,4,5.
- **Conversion pulses inside the busy window.** A design counting them would start the burst off-position.
- **First equal to last.** A design handling this wrongly would never emit `burst_done`, or would emit it only every other pulse.
- **Write arriving together with a conversion pulse.** A design handling this wrongly would advance past the freshly loaded first channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  parameter int SCAN_CH_W = 4;
  typedef logic [SCAN_CH_W-1:0] chan_t;

  typedef struct packed {
    chan_t last;
    chan_t first;
  } scan_cfg_t;

  // Differential mode drops the top bit of every channel code.
  function automatic chan_t lane_mask(input logic diff);
    chan_t m;
    m = '1;
    if (diff) m[SCAN_CH_W-1] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import adc_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  scan_cfg_t wr_data,
  output scan_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (wr) cfg <= wr_data;
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) remain <= '0;
    else if (start) remain <= LOAD;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/scan_stepper.sv
module scan_stepper
  import adc_scan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  chan_t load_first,
  input  logic  adv,
  input  chan_t first,
  input  chan_t last,
  input  chan_t mask,
  output chan_t cur,
  output logic  done
);
  chan_t cur_q;
  chan_t cur_eff;
  chan_t nxt;
  logic  at_last;

  assign cur_eff = cur_q & mask;
  assign at_last = (cur_eff == (last & mask));
  assign nxt     = (cur_eff + 1'b1) & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        cur_q <= load_first & mask;
      end else if (adv) begin
        if (at_last) begin
          cur_q <= first & mask;
          done  <= 1'b1;
        end else begin
          cur_q <= nxt;
        end
      end
    end
  end

  assign cur = cur_eff;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  input  logic       diff_mode,
  input  logic       conv_done,
  output logic [3:0] chan,
  output logic       burst_done,
  output logic       rst_busy
);
  scan_cfg_t cfg;
  scan_cfg_t wr_cfg;
  chan_t     mask;
  logic      adv;

  assign wr_cfg = scan_cfg_t'(cfg_data);
  assign mask   = lane_mask(diff_mode);
  assign adv    = conv_done & ~rst_busy & ~cfg_wr;

  scan_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_data(wr_cfg), .cfg(cfg)
  );

  busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(cfg_wr), .busy(rst_busy)
  );

  scan_stepper u_step (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_first(wr_cfg.first),
    .adv(adv), .first(cfg.first), .last(cfg.last), .mask(mask),
    .cur(chan), .done(burst_done)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_data,
  input logic       diff_mode,
  input logic       conv_done,
  input logic [3:0] chan,
  input logic       burst_done,
  input logic       rst_busy
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr || !rst_busy) busy_run <= 0;
    else busy_run <= busy_run + 1;
  end

  assert_load_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!$stable(diff_mode) ||
                chan == ($past(cfg_data[3:0]) & lane_mask(diff_mode))));

  assert_busy_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> rst_busy);

  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> busy_run < BUSY_CYCLES);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && !cfg_wr) |=> (!$stable(diff_mode) || $stable(chan)));

  assert_busy_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy || cfg_wr) |=> !burst_done);

  assert_done_after_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(conv_done));

  assert_diff_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    diff_mode |-> !chan[3]);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !cfg_wr) |=> (!$stable(diff_mode) || $stable(chan)));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
  .diff_mode(diff_mode), .conv_done(conv_done), .chan(chan),
  .burst_done(burst_done), .rst_busy(rst_busy)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       diff_mode = 1'b0;
  logic       conv_done = 1'b0;
  logic [3:0] chan;
  logic       burst_done;
  logic       rst_busy;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  int m_first = 0, m_last = 0, m_chan = 0, m_busy = 0;
  bit m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .diff_mode(diff_mode), .conv_done(conv_done), .chan(chan),
    .burst_done(burst_done), .rst_busy(rst_busy)
  );

  function automatic int modn();
    return diff_mode ? 8 : 16;
  endfunction

  task automatic model_step();
    int b0;
    if (!rst_n) begin
      m_first = 0; m_last = 0; m_chan = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      b0 = m_busy;
      if (cfg_wr) begin
        m_first = cfg_data[3:0];
        m_last  = cfg_data[7:4];
        m_chan  = m_first % modn();
        m_busy  = BUSY;
      end else begin
        if (b0 > 0) m_busy = b0 - 1;
        if (conv_done && b0 == 0) begin
          if ((m_chan % modn()) == (m_last % modn())) begin
            m_chan = m_first % modn();
            m_done = 1;
          end else begin
            m_chan = ((m_chan % modn()) + 1) % modn();
          end
        end
      end
    end
  endtask

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("chan", int'(chan), m_chan % modn());
    check("burst_done", int'(burst_done), int'(m_done));
    check("rst_busy", int'(rst_busy), (m_busy > 0) ? 1 : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic write_cfg(input int first, input int last);
    cfg_wr = 1'b1;
    cfg_data = {4'(last), 4'(first)};
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic conv();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < BUSY; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    check("chan after reset", int'(chan), 0);
    check("busy after reset", int'(rst_busy), 0);

    // R2/R3: write FC=3 LC=13, busy window
    tag = "R2";
    write_cfg(3, 13);
    check("chan loads first", int'(chan), 3);
    tag = "R3";
    check("busy after write", int'(rst_busy), 1);
    // R4: conv pulses during busy are ignored
    tag = "R4";
    conv(); conv();
    check("chan held in busy", int'(chan), 3);
    tick(); tick();
    tag = "R3";
    check("busy ended", int'(rst_busy), 0);

    // R5/R6: step 3..13 and reload
    tag = "R5";
    for (int i = 0; i < 10; i++) begin
      conv();
      check("step", int'(chan), 4 + i);
    end
    tag = "R6";
    conv();
    check("reload first", int'(chan), 3);
    check("burst_done pulse", int'(burst_done), 1);
    tick();
    check("burst_done one cycle", int'(burst_done), 0);

    // R9: idle hold
    tag = "R9";
    for (int i = 0; i < 5; i++) tick();
    check("idle hold", int'(chan), 3);

    // R7: wrapped scan 9..15,0,1,9
    tag = "R7";
    write_cfg(9, 1);
    settle();
    for (int i = 1; i <= 9; i++) begin
      conv();
      check("wrap sequence", int'(chan), (i <= 8) ? (9 + i) % 16 : 9);
    end

    // R8: differential 3,4,5,3
    tag = "R8";
    diff_mode = 1'b1;
    write_cfg(3, 13);
    settle();
    check("diff first", int'(chan), 3);
    conv(); check("diff step", int'(chan), 4);
    conv(); check("diff step", int'(chan), 5);
    conv(); check("diff reload", int'(chan), 3);
    check("diff burst_done", int'(burst_done), 1);
    write_cfg(12, 9); // effective 4..1 wraps modulo 8
    settle();
    for (int i = 0; i < 7; i++) conv();
    check("diff msb clear", int'(chan[3]), 0);
    diff_mode = 1'b0;
    tick();

    // R6: first equal to last gives done on every pulse
    tag = "R6";
    write_cfg(7, 7);
    settle();
    for (int i = 0; i < 3; i++) begin
      conv();
      check("single channel done", int'(burst_done), 1);
      check("single channel chan", int'(chan), 7);
      conv_done = 1'b0;
    end

    // R4: write coincident with conversion pulse
    tag = "R4";
    conv_done = 1'b1;
    write_cfg(2, 5);
    conv_done = 1'b0;
    check("write wins over conv", int'(chan), 2);
    // R3: rewrite during busy restarts window
    tag = "R3";
    tick();
    write_cfg(2, 5);
    for (int i = 0; i < BUSY - 1; i++) tick();
    check("busy still high", int'(rst_busy), 1);
    tick();
    check("busy dropped", int'(rst_busy), 0);

    // mixed random-ish traffic, model compares each cycle
    tag = "R5";
    for (int i = 0; i < 200; i++) begin
      conv_done = ((i * 7) % 3) != 0;
      diff_mode = ((i / 50) % 2) == 1;
      if (i % 37 == 5) begin
        cfg_wr = 1'b1;
        cfg_data = 8'((i * 29) % 256);
      end
      tick();
      cfg_wr = 1'b0;
    end
    conv_done = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule